// File: doc/BRIEF.md
# Bit-Plane Grayscale PWM Engine

This block turns a set of per-channel intensity words into binary-weighted on/off patterns for a bank of output channels. A single tick counter defines a fixed refresh frame. Each frame opens and closes with a blanking interval during which every output is held low. Between the two blanking intervals, one time slice per bit of the quantized code is issued, least significant bit first, and slice k is twice as long as slice k-1.

Intensities are written one channel at a time into a staging copy. A commit request marks that copy for display. The copy is moved into the displayed set only at the frame boundary, so a half-written look never reaches the pins. At that boundary every channel is multiplied by one shared brightness factor. The product is split into a displayed code and a fractional remainder. The remainder is spread over a cycle of frames by comparing it with a bit-reversed frame index, which adds effective grayscale depth beyond the slice count.

Two saturating counters report problems. One counts commits that arrive inside the closing blank, which is too late for the coming boundary. The other counts slices that were dropped because the blanking left too little room for them in the frame.

Top module: `bitplane_pwm`

## Requirements
- R1: The frame is exactly FRAME_TICKS clocks long. `frame_start_o` is high for one clock at tick 0 of every frame, and all channels are timed from this one counter.
- R2: A write to the staging copy without a commit never changes what any output shows.
- R3: A commit requested outside the closing blank takes effect at the next frame boundary and is consumed there, only once. A second write and commit before that boundary replace the staged data and do not count as a miss.
- R4: A commit requested while `tick + blank_len_i >= FRAME_TICKS` is late. The late-commit counter rises by exactly one per closing window, however many requests arrive in that window. The commit takes effect at the boundary after next.
- R5: `blank_o` is high for ticks below `blank_len_i` and for ticks at or above FRAME_TICKS - `blank_len_i`. All of `pwm_o` is low whenever `blank_o` is high.
- R6: Slice k begins at tick `blank_len_i + BASE_TICKS*(2^k-1)` and lasts `BASE_TICKS*2^k` clocks. A channel is high during slice k exactly when bit k of its code is 1, so its on-time per frame is BASE_TICKS times its code.
- R7: Every channel's value v is scaled the same way: e = (v*(scale_i+1)) >> SCALE_W, with scale_i sampled at the frame boundary.
- R8: The code is e >> DITH_BITS, plus 1 when the low DITH_BITS bits of e exceed the bit-reversed frame index (mod 2^DITH_BITS). A code already at its maximum is not incremented. Over 2^DITH_BITS consecutive frames, the codes therefore sum to 2^DITH_BITS times the integer part plus the fraction.
- R9: A slice whose end would fall after FRAME_TICKS - `blank_len_i` is not issued. At each frame boundary, the missed-slice counter rises by the number of such slices.
- R10: During and right after reset, all outputs are low, both counters read zero, `frame_start_o` is high, and the staged and displayed values are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Write strobe for the staging copy |
| wr_ch_i | input | CH_W | Channel written |
| wr_data_i | input | IN_W | Intensity written |
| commit_req_i | input | 1 | Request to display the staged copy |
| scale_i | input | SCALE_W | Global brightness factor (all ones = unity) |
| blank_len_i | input | TICK_W | Blanking length in ticks at each frame edge |
| pwm_o | output | NCH | Channel outputs |
| frame_start_o | output | 1 | High at tick 0 |
| blank_o | output | 1 | High inside a blanking interval |
| miss_commit_o | output | CNT_W | Saturating count of late commits |
| miss_plane_o | output | CNT_W | Saturating count of dropped slices |

## Verification
The hardest state to reach from the pins is a commit that lands in the last few ticks of a frame. A second request then arrives in the same window, and the carried commit must survive one full frame of stale output. The bench gets there by aligning to `frame_start_o` and counting clocks up to the closing blank. It issues two back-to-back late requests, then measures the next two frames one after the other. Dropped slices are forced by raising the blanking length past the point where the widest slices still fit. Dithering is judged by summing the on-time over a full cycle of frames, for values whose fraction is zero, non-zero and saturated.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
  typedef enum logic [1:0] {
    PH_HEAD = 2'd0,
    PH_BODY = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;
endpackage

// File: rtl/bpp_timebase.sv
module bpp_timebase
  import bpp_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 4400,
  parameter int unsigned PLANE_BITS  = 12,
  parameter int unsigned BASE_TICKS  = 1,
  parameter int unsigned CNT_W       = 16,
  localparam int unsigned TICK_W     = $clog2(FRAME_TICKS),
  localparam int unsigned NM_W       = $clog2(PLANE_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TICK_W-1:0]     blank_len_i,
  output logic                  latch_o,
  output logic                  frame_start_o,
  output logic                  blank_o,
  output logic                  tail_o,
  output logic [PLANE_BITS-1:0] plane_on_o,
  output logic [CNT_W-1:0]      miss_plane_o
);
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [CNT_W-1:0]  miss_q, miss_d;
  logic [31:0]       t32, b32, off32;
  logic [PLANE_BITS-1:0] fits;
  logic [NM_W-1:0]   n_drop;
  logic [CNT_W:0]    miss_sum;
  phase_e            phase;

  assign t32   = 32'(tick_q);
  assign b32   = 32'(blank_len_i);
  assign off32 = t32 - b32;

  assign latch_o       = (tick_q == TICK_W'(FRAME_TICKS - 1));
  assign frame_start_o = (tick_q == '0);
  assign tail_o        = (t32 + b32 >= FRAME_TICKS);

  always_comb begin
    if (t32 < b32)   phase = PH_HEAD;
    else if (tail_o) phase = PH_TAIL;
    else             phase = PH_BODY;
  end
  assign blank_o = (phase != PH_BODY);

  // slice schedule: LSB first, each slice twice the previous
  for (genvar k = 0; k < PLANE_BITS; k++) begin : g_plane
    localparam int unsigned LO = BASE_TICKS * ((32'd1 << k) - 1);
    localparam int unsigned HI = BASE_TICKS * ((32'd1 << (k + 1)) - 1);
    assign fits[k]       = (b32 + b32 + HI) <= FRAME_TICKS;
    assign plane_on_o[k] = (phase == PH_BODY) && fits[k] && (off32 >= LO) && (off32 < HI);
  end

  always_comb begin
    n_drop = '0;
    for (int k = 0; k < PLANE_BITS; k++) n_drop = n_drop + NM_W'(!fits[k]);
  end

  always_comb begin
    tick_d   = latch_o ? '0 : tick_q + 1'b1;
    miss_sum = {1'b0, miss_q} + (CNT_W+1)'(n_drop);
    miss_d   = miss_sum[CNT_W] ? '1 : miss_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      miss_q <= '0;
    end else begin
      tick_q <= tick_d;
      if (latch_o) miss_q <= miss_d;
    end
  end

  assign miss_plane_o = miss_q;
endmodule

// File: rtl/bpp_buffers.sv
module bpp_buffers #(
  parameter int unsigned NCH   = 16,
  parameter int unsigned IN_W  = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  logic [IN_W-1:0] wr_data_i,
  input  logic            commit_req_i,
  input  logic            tail_i,
  input  logic            latch_i,
  output logic [IN_W-1:0] front_nxt_o [NCH],
  output logic [CNT_W-1:0] miss_commit_o
);
  logic [IN_W-1:0] back_q [NCH];
  logic [IN_W-1:0] front_q [NCH];
  logic pend_q, pend_d, late_q, late_d;
  logic early, late, swap, miss_inc;
  logic [CNT_W-1:0] miss_q, miss_d;

  assign early    = commit_req_i & ~tail_i;
  assign late     = commit_req_i & tail_i;
  assign swap     = latch_i & (pend_q | early);
  assign miss_inc = late & ~late_q;

  always_comb begin
    if (latch_i) begin
      pend_d = late_q | late;
      late_d = 1'b0;
    end else begin
      pend_d = pend_q | early;
      late_d = late_q | late;
    end
    miss_d = (miss_inc && !(&miss_q)) ? miss_q + 1'b1 : miss_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      late_q <= 1'b0;
      miss_q <= '0;
    end else begin
      pend_q <= pend_d;
      late_q <= late_d;
      miss_q <= miss_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_hit;
    assign wr_hit         = wr_en_i && (wr_ch_i == CH_W'(c));
    assign front_nxt_o[c] = swap ? back_q[c] : front_q[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        back_q[c]  <= '0;
        front_q[c] <= '0;
      end else begin
        if (wr_hit) back_q[c]  <= wr_data_i;
        if (swap)   front_q[c] <= back_q[c];
      end
    end
  end

  assign miss_commit_o = miss_q;
endmodule

// File: rtl/bpp_shaper.sv
module bpp_shaper #(
  parameter int unsigned NCH        = 16,
  parameter int unsigned PLANE_BITS = 12,
  parameter int unsigned DITH_BITS  = 4,
  parameter int unsigned SCALE_W    = 8,
  localparam int unsigned IN_W      = PLANE_BITS + DITH_BITS,
  localparam int unsigned PROD_W    = IN_W + SCALE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      latch_i,
  input  logic [IN_W-1:0]           front_nxt_i [NCH],
  input  logic [SCALE_W-1:0]        scale_i,
  input  logic [PLANE_BITS-1:0]     plane_on_i,
  output logic [NCH-1:0]            pwm_o,
  output logic [NCH*PLANE_BITS-1:0] codes_o
);
  logic [DITH_BITS-1:0] fcnt_q, fcnt_d, thr;
  logic [SCALE_W:0]     scl1;

  assign fcnt_d = fcnt_q + 1'b1;
  assign scl1   = {1'b0, scale_i} + (SCALE_W+1)'(1);

  // ordered pattern: bit-reversed frame index
  for (genvar b = 0; b < DITH_BITS; b++) begin : g_rev
    assign thr[b] = fcnt_d[DITH_BITS-1-b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fcnt_q <= '0;
    else if (latch_i) fcnt_q <= fcnt_d;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [IN_W-1:0]       eff;
    logic [PLANE_BITS-1:0] hi, code_q, code_d;
    logic [DITH_BITS-1:0]  frac;
    logic                  bump;

    assign eff  = IN_W'((PROD_W'(front_nxt_i[c]) * PROD_W'(scl1)) >> SCALE_W);
    assign hi   = eff[IN_W-1:DITH_BITS];
    assign frac = eff[DITH_BITS-1:0];
    assign bump = (frac > thr) && !(&hi);

    always_comb code_d = hi + PLANE_BITS'(bump);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_q <= '0;
      else if (latch_i) code_q <= code_d;
    end

    assign pwm_o[c] = |(code_q & plane_on_i);
    assign codes_o[c*PLANE_BITS +: PLANE_BITS] = code_q;
  end
endmodule

// File: rtl/bitplane_pwm.sv
module bitplane_pwm #(
  parameter int unsigned NCH         = 16,
  parameter int unsigned PLANE_BITS  = 12,
  parameter int unsigned DITH_BITS   = 4,
  parameter int unsigned SCALE_W     = 8,
  parameter int unsigned BASE_TICKS  = 1,
  parameter int unsigned FRAME_TICKS = 4400,
  parameter int unsigned CNT_W       = 16,
  localparam int unsigned IN_W       = PLANE_BITS + DITH_BITS,
  localparam int unsigned CH_W       = $clog2(NCH),
  localparam int unsigned TICK_W     = $clog2(FRAME_TICKS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [CH_W-1:0]    wr_ch_i,
  input  logic [IN_W-1:0]    wr_data_i,
  input  logic               commit_req_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [TICK_W-1:0]  blank_len_i,
  output logic [NCH-1:0]     pwm_o,
  output logic               frame_start_o,
  output logic               blank_o,
  output logic [CNT_W-1:0]   miss_commit_o,
  output logic [CNT_W-1:0]   miss_plane_o
);
  logic rst_meta, rst_sn;
  logic latch, tail;
  logic [PLANE_BITS-1:0]     plane_on;
  logic [IN_W-1:0]           front_nxt [NCH];
  logic [NCH*PLANE_BITS-1:0] codes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, rst_sn} <= 2'b00;
    else        {rst_meta, rst_sn} <= {1'b1, rst_meta};
  end

  bpp_timebase #(
    .FRAME_TICKS(FRAME_TICKS), .PLANE_BITS(PLANE_BITS),
    .BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)
  ) u_tb (
    .clk(clk), .rst_n(rst_sn), .blank_len_i(blank_len_i),
    .latch_o(latch), .frame_start_o(frame_start_o), .blank_o(blank_o),
    .tail_o(tail), .plane_on_o(plane_on), .miss_plane_o(miss_plane_o)
  );

  bpp_buffers #(.NCH(NCH), .IN_W(IN_W), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_sn), .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i),
    .wr_data_i(wr_data_i), .commit_req_i(commit_req_i), .tail_i(tail),
    .latch_i(latch), .front_nxt_o(front_nxt), .miss_commit_o(miss_commit_o)
  );

  bpp_shaper #(
    .NCH(NCH), .PLANE_BITS(PLANE_BITS), .DITH_BITS(DITH_BITS), .SCALE_W(SCALE_W)
  ) u_shp (
    .clk(clk), .rst_n(rst_sn), .latch_i(latch), .front_nxt_i(front_nxt),
    .scale_i(scale_i), .plane_on_i(plane_on), .pwm_o(pwm_o), .codes_o(codes)
  );
endmodule

// File: rtl/bitplane_pwm_chk.sv
module bitplane_pwm_chk #(
  parameter int unsigned NCH         = 16,
  parameter int unsigned PLANE_BITS  = 12,
  parameter int unsigned FRAME_TICKS = 4400,
  parameter int unsigned CNT_W       = 16,
  localparam int unsigned TICK_W     = $clog2(FRAME_TICKS)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      commit_req_i,
  input logic                      blank_o,
  input logic                      frame_start_o,
  input logic [NCH-1:0]            pwm_o,
  input logic [PLANE_BITS-1:0]     plane_on,
  input logic [NCH*PLANE_BITS-1:0] codes,
  input logic [CNT_W-1:0]          miss_commit_o,
  input logic [CNT_W-1:0]          miss_plane_o
);
  logic [TICK_W-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= (cyc_q == TICK_W'(FRAME_TICKS - 1)) ? '0 : cyc_q + 1'b1;
  end

  AST_FRAME_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o == (cyc_q == '0)); // R1
  AST_CODES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_o |-> $stable(codes)); // R2
  AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> (pwm_o == '0)); // R5
  AST_ONE_SLICE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(plane_on)); // R6
  AST_LATE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_commit_o != $past(miss_commit_o)) |->
      ((miss_commit_o - $past(miss_commit_o)) == CNT_W'(1)) && $past(commit_req_i && blank_o)); // R4
  AST_DROP_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_plane_o != $past(miss_plane_o)) |-> frame_start_o); // R9
endmodule

bind bitplane_pwm bitplane_pwm_chk #(
  .NCH(NCH), .PLANE_BITS(PLANE_BITS), .FRAME_TICKS(FRAME_TICKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_sn), .commit_req_i(commit_req_i), .blank_o(blank_o),
  .frame_start_o(frame_start_o), .pwm_o(pwm_o), .plane_on(plane_on), .codes(codes),
  .miss_commit_o(miss_commit_o), .miss_plane_o(miss_plane_o)
);

// File: tb/test_bitplane_pwm.sv
`timescale 1ns/1ps
module test_bitplane_pwm;
  localparam int NCH = 3, PB = 4, DB = 2, SW = 4, BT = 2, FT = 40, CW = 8;
  localparam int IW = PB + DB, CHW = 2, TW = 6;

  logic clk = 1'b0, rst_n;
  logic wr_en, commit;
  logic [CHW-1:0] wr_ch;
  logic [IW-1:0]  wr_data;
  logic [SW-1:0]  scale;
  logic [TW-1:0]  blank;
  logic [NCH-1:0] pwm;
  logic fstart, blank_o;
  logic [CW-1:0] miss_c, miss_p;

  int n_chk = 0, n_err = 0;

  bitplane_pwm #(.NCH(NCH), .PLANE_BITS(PB), .DITH_BITS(DB), .SCALE_W(SW),
                 .BASE_TICKS(BT), .FRAME_TICKS(FT), .CNT_W(CW)) i_bitplane_pwm (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_data_i(wr_data),
    .commit_req_i(commit), .scale_i(scale), .blank_len_i(blank), .pwm_o(pwm),
    .frame_start_o(fstart), .blank_o(blank_o), .miss_commit_o(miss_c), .miss_plane_o(miss_p));

  always #2.5 clk = ~clk;

  // value, scale, expected ch0 on-time summed over 4 frames
  localparam int VEC [8][3] = '{
    '{0, 15, 0}, '{63, 15, 120}, '{5, 15, 10}, '{22, 15, 44},
    '{40, 7, 40}, '{63, 7, 62}, '{13, 3, 6}, '{60, 15, 120}};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sum4(input int v, input int s);
    int e, hi, f;
    e = (v * (s + 1)) >> SW; hi = e >> DB; f = e & 3;
    if (hi == 15 && f > 0) return BT * 4 * 15;
    return BT * (4 * hi + f);
  endfunction

  task automatic to_fs;
    @(negedge clk);
    while (!fstart) @(negedge clk);
  endtask

  task automatic wr(input int ch, input int v);
    wr_en = 1'b1; wr_ch = CHW'(ch); wr_data = IW'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_commit;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  task automatic measure(input int nf, input bit align, output int c0, output int c1,
                         output int c2, output int bl, output int dk, output int fs,
                         output int first0);
    c0 = 0; c1 = 0; c2 = 0; bl = 0; dk = 0; fs = 0; first0 = -1;
    if (align) to_fs();
    for (int i = 0; i < nf * FT; i++) begin
      c0 += int'(pwm[0]); c1 += int'(pwm[1]); c2 += int'(pwm[2]);
      if (i < FT) bl += int'(blank_o);
      fs += int'(fstart);
      if (blank_o && pwm != '0) dk++;
      if (first0 < 0 && pwm[0]) first0 = i % FT;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int c0, c1, c2, bl, dk, fs, f0, m0;
    rst_n = 1'b0; wr_en = 1'b0; commit = 1'b0; wr_ch = '0; wr_data = '0;
    scale = 4'd15; blank = 6'd3;
    repeat (4) @(negedge clk);
    chk("R10 pwm in reset", int'(pwm), 0);
    chk("R10 late count in reset", int'(miss_c), 0);
    chk("R10 drop count in reset", int'(miss_p), 0);
    chk("R10 frame_start in reset", int'(fstart), 1);
    rst_n = 1'b1;
    measure(1, 1'b1, c0, c1, c2, bl, dk, fs, f0);
    chk("R10 outputs dark after reset", c0 + c1 + c2, 0);
    chk("R5 blank ticks per frame", bl, 6);

    for (int i = 0; i < 8; i++) begin
      to_fs();
      scale = SW'(VEC[i][1]);
      wr(0, VEC[i][0]); wr(1, VEC[i][0] >> 1); wr(2, VEC[i][0] >> 2);
      pulse_commit();
      measure(4, 1'b1, c0, c1, c2, bl, dk, fs, f0);
      chk($sformatf("R8 ch0 dithered on-time vec %0d", i), c0, VEC[i][2]);
      chk($sformatf("R7 ch1 scaled vec %0d", i), c1, exp_sum4(VEC[i][0] >> 1, VEC[i][1]));
      chk($sformatf("R7 ch2 scaled vec %0d", i), c2, exp_sum4(VEC[i][0] >> 2, VEC[i][1]));
      chk($sformatf("R5 dark in blank vec %0d", i), dk, 0);
      chk($sformatf("R1 frame starts vec %0d", i), fs, 4);
    end
    scale = 4'd15;

    // R6: slice order and position
    to_fs(); wr(0, 4); pulse_commit();
    measure(1, 1'b1, c0, c1, c2, bl, dk, fs, f0);
    chk("R6 code 1 on-time", c0, 2);
    chk("R6 code 1 first tick", f0, 3);
    to_fs(); wr(0, 32); pulse_commit();
    measure(1, 1'b1, c0, c1, c2, bl, dk, fs, f0);
    chk("R6 code 8 on-time", c0, 16);
    chk("R6 code 8 first tick", f0, 17);

    // R2: staged write without commit is not shown
    to_fs(); wr(0, 40); pulse_commit();
    measure(1, 1'b1, c0, c1, c2, bl, dk, fs, f0);
    chk("R3 committed value shown", c0, 20);
    to_fs(); wr(0, 8);
    measure(1, 1'b1, c0, c1, c2, bl, dk, fs, f0);
    chk("R2 uncommitted write hidden", c0, 20);

    // R3: overwrite before the boundary
    m0 = int'(miss_c);
    to_fs(); wr(0, 8); pulse_commit(); wr(0, 24); pulse_commit();
    measure(1, 1'b1, c0, c1, c2, bl, dk, fs, f0);
    chk("R3 second staged value wins", c0, 12);
    chk("R3 early commits not late", int'(miss_c), m0);

    // R4: late commit in closing blank, twice in one window
    m0 = int'(miss_c);
    to_fs(); wr(0, 8);
    repeat (37) @(negedge clk);
    commit = 1'b1;
    @(negedge clk);
    @(negedge clk);
    commit = 1'b0;
    chk("R4 late counted once", int'(miss_c), m0 + 1);
    measure(1, 1'b0, c0, c1, c2, bl, dk, fs, f0);
    chk("R4 late commit not at next boundary", c0, 12);
    measure(1, 1'b0, c0, c1, c2, bl, dk, fs, f0);
    chk("R4 late commit applied one frame later", c0, 4);

    // R9: dropped slices versus blank length
    to_fs(); wr(0, 60); pulse_commit();
    to_fs(); blank = 6'd5;
    to_fs(); m0 = int'(miss_p);
    measure(1, 1'b0, c0, c1, c2, bl, dk, fs, f0);
    chk("R9 exact fit on-time", c0, 30);
    chk("R9 exact fit no drop", int'(miss_p), m0);
    chk("R5 blank 5 ticks", bl, 10);
    to_fs(); blank = 6'd6;
    to_fs(); m0 = int'(miss_p);
    measure(1, 1'b0, c0, c1, c2, bl, dk, fs, f0);
    chk("R9 widest slice dropped on-time", c0, 14);
    chk("R9 one drop counted", int'(miss_p), m0 + 1);
    to_fs(); blank = 6'd14;
    to_fs(); m0 = int'(miss_p);
    measure(1, 1'b0, c0, c1, c2, bl, dk, fs, f0);
    chk("R9 two slices dropped on-time", c0, 6);
    chk("R9 two drops counted", int'(miss_p), m0 + 2);
    chk("R5 dark with wide blank", dk, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule